// File: doc/BRIEF.md
# Boot-Sector NOR Flash Command and Status Controller

This block is the control core of a NOR flash device with a boot-sector layout. Host bus cycles arrive on the chip-enable, write-enable and output-enable strobes together with address, data and a byte/word select. The block turns them into program, sector-erase, chip-erase, erase-suspend and erase-resume operations. Each operation is carried out as an embedded sequence against a generic word-wide array port, timed by cycle counters. Program merges, writes and verifies one location. Erase preprograms every selected word to zero, waits out the erase time, then writes and verifies all ones.

While an operation runs, host reads return status bits instead of array data and the ready output is low. Protected sectors and a low-supply input stop writes. An erase can be suspended so that other sectors can be read or programmed, and then resumed at the point where it stopped. The active-low reset aborts any operation and returns the block to reading the array.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: While rst_n is low, rdy is high. Releasing rst_n leaves the block in array-read mode with any running operation abandoned and any partial command sequence cleared.
- R2: A command needs two unlock writes: 0xAA to address 0x555, then 0x55 to 0x2AA. Only the lowest min(11, ADDR_W) address bits are compared. A third write to 0x555 then gives the code: 0xA0 for program or 0x80 for erase setup. Erase setup needs two more unlock writes and then 0x10 for chip erase or 0x30 (at a sector address) for sector erase. Any write that breaks a sequence returns the decoder to read mode without starting anything.
- R3: In word mode a program stores the old word ANDed with the written data at the addressed word. Completion waits for a read-back that matches.
- R4: When byte_n is low, dq_in[15] acts as the lowest byte address bit. A value of 1 selects bits 15:8 of the word and 0 selects bits 7:0. Programming changes only that byte. Reads return the byte on dq_out[7:0] with dq_out[15:8] at zero.
- R5: A host read during a busy operation returns status with every bit zero except three. Bit 7 is the complement of written data bit 7 during a program and 0 during an erase. Bit 6 flips between successive reads.
- R6: rdy is low from the cycle after the command's last write until the operation completes. It is high in read mode and in erase suspend.
- R7: The sector map, as a fraction of the word space, is 1/32, 1/64, 1/64 and 1/16 at the bottom, numbered 0 to 3, followed by seven sectors of 1/8 each, numbered 4 to 10. After a sector erase command, each further 0x30 write within WIN_CYC cycles adds the addressed sector. Once the window closes, every selected sector becomes 0xFFFF and unselected sectors are unchanged.
- R8: Chip erase sets every word of every unprotected sector to 0xFFFF.
- R9: Bit 2 of the status flips between successive reads only when the read address lies in a sector selected for the running or suspended erase. During a program it holds.
- R10: Writing 0xB0 during the preprogram, timed or wipe phase of an erase suspends it (rdy high). In suspend, unselected sectors read as array data and can be programmed. Reads of selected sectors return status with bit 7 at 1 and bit 6 held. Programs to selected sectors are ignored. Writing 0x30 resumes the erase.
- R11: A program or erase aimed at a sector whose sec_lock bit is set leaves that sector unchanged. A program to it does not make the block busy.
- R12: While vlow is high, write cycles are ignored entirely.
- R13: Writes during a busy operation are ignored, except suspend during an erase and 0x30 during the sector-add window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, aborts operations |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable; a write is taken on its falling edge |
| oe_n | input | 1 | Active-low output enable |
| byte_n | input | 1 | Low selects byte mode |
| vlow | input | 1 | Low-supply detect, blocks writes |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Host data; bit 15 is the byte address bit in byte mode |
| sec_lock | input | 11 | Per-sector protection |
| dq_out | output | 16 | Read data or status |
| dq_oe | output | 1 | Output drive enable during a read |
| rdy | output | 1 | High when ready, low while busy |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | 16 | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_rdata | input | 16 | Array read data for arr_addr, combinational |

## Verification
Programs are tried in word mode on an erased word and on an already written word, so the AND merge is told apart from a plain overwrite. A byte-mode program into the upper lane shows that the other byte survives. Erases are tried on one sector, on two sectors gathered in the add window and on the whole chip with one sector protected, which separates sector selection from protection. Status reads are compared between addresses inside and outside the erasing sectors, and before and after suspend, to separate the roles of bits 2 and 6. Broken unlock sequences, low supply, writes while busy and a mid-erase reset each show that nothing starts or that the block recovers to array data.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64,
  parameter int WIN_CYC   = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              byte_n,
  input  logic              vlow,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  input  logic [10:0]       sec_lock,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic              rdy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [15:0]       arr_wdata,
  output logic              arr_we,
  input  logic [15:0]       arr_rdata
);
  localparam int NSEC = 11;
  localparam int E    = ADDR_W - 3;
  localparam int CW   = (ADDR_W < 11) ? ADDR_W : 11;
  localparam int TA   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TMAX = (TA > WIN_CYC) ? TA : WIN_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [2:0] C0 = 3'd0, C1 = 3'd1, C2 = 3'd2, C3 = 3'd3,
                         C4 = 3'd4, C5 = 3'd5, C6 = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_PW, S_PV, S_EWIN, S_EPRE, S_ETIM, S_EWIPE, S_SUSP
  } st_t;

  function automatic logic [3:0] sec_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:E] != 3'd0)       return 4'd3 + 4'(a[ADDR_W-1:E]);
    else if (a[E-1])                 return 4'd3;
    else if (a[E-2:E-3] == 2'b11)    return 4'd2;
    else if (a[E-2:E-3] == 2'b10)    return 4'd1;
    else                             return 4'd0;
  endfunction

  st_t              st, e_phase;
  logic [2:0]       cs;
  logic             we_q, rd_q, t6en, t2en, tog6, tog2, p_d7, insusp;
  logic [ADDR_W-1:0] p_addr, e_addr;
  logic [15:0]      p_tgt;
  logic [NSEC-1:0]  e_sel;
  logic [TW-1:0]    ptmr, etmr;

  wire [7:0]  cmd      = dq_in[7:0];
  wire        wr       = ~ce_n & ~we_n & we_q & oe_n & ~vlow;
  wire        rd_act   = ~ce_n & ~oe_n & we_n;
  wire        rd_end   = rd_q & ~rd_act;
  wire        a555     = addr[CW-1:0] == CW'(11'h555);
  wire        a2aa     = addr[CW-1:0] == CW'(11'h2AA);
  wire        is1      = a555 && cmd == 8'hAA;
  wire        is2      = a2aa && cmd == 8'h55;
  wire [3:0]  sec_host = sec_of(addr);
  wire        sel_host = e_sel[sec_host];
  wire        lck_host = sec_lock[sec_host];
  wire [NSEC-1:0] host_bit = NSEC'(1) << sec_host;
  wire [NSEC-1:0] chip_mask = ~sec_lock;
  wire        busy_st  = st != S_IDLE && st != S_SUSP;
  wire        prog_st  = st == S_PW || st == S_PV;
  wire        erase_bz = st == S_EWIN || st == S_EPRE || st == S_ETIM || st == S_EWIPE;
  wire        erase_cx = erase_bz || st == S_SUSP;
  wire        e_last   = &e_addr;
  wire        lane     = dq_in[15];

  wire [15:0] merged = byte_n ? (arr_rdata & dq_in) :
                       lane   ? {arr_rdata[15:8] & cmd, arr_rdata[7:0]} :
                                {arr_rdata[15:8], arr_rdata[7:0] & cmd};

  assign rdy = ~busy_st;

  always_comb begin
    arr_addr  = addr;
    arr_wdata = p_tgt;
    arr_we    = 1'b0;
    case (st)
      S_PW: begin arr_addr = p_addr; arr_we = ptmr == '0; end
      S_PV: arr_addr = p_addr;
      S_EPRE: begin
        arr_addr  = e_addr;
        arr_wdata = 16'h0000;
        arr_we    = e_sel[sec_of(e_addr)] && arr_rdata != 16'h0000;
      end
      S_EWIPE: begin
        arr_addr  = e_addr;
        arr_wdata = 16'hFFFF;
        arr_we    = e_sel[sec_of(e_addr)] && arr_rdata != 16'hFFFF;
      end
      default: ;
    endcase
  end

  wire        d7   = prog_st ? ~p_d7 : (st == S_SUSP);
  wire [15:0] stat = {8'h00, d7, tog6, 3'b000, tog2, 2'b00};
  wire        show = busy_st || (st == S_SUSP && sel_host);
  wire [15:0] src  = show ? stat : arr_rdata;

  assign dq_oe  = rd_act;
  assign dq_out = byte_n ? src :
                  {8'h00, (show || !lane) ? src[7:0] : src[15:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; e_phase <= S_EPRE; cs <= C0;
      we_q <= 1'b1; rd_q <= 1'b0; t6en <= 1'b0; t2en <= 1'b0;
      tog6 <= 1'b0; tog2 <= 1'b0; p_d7 <= 1'b0; insusp <= 1'b0;
      p_addr <= '0; e_addr <= '0; p_tgt <= '0; e_sel <= '0;
      ptmr <= '0; etmr <= '0;
    end else begin
      we_q <= we_n;
      rd_q <= rd_act;
      if (rd_act) begin
        t6en <= busy_st;
        t2en <= erase_cx && sel_host;
      end
      if (rd_end && t6en) tog6 <= ~tog6;
      if (rd_end && t2en) tog2 <= ~tog2;

      case (st)
        S_IDLE, S_SUSP: if (wr) begin
          cs <= C0;
          case (cs)
            C0: if (is1) cs <= C1;
                else if (st == S_SUSP && cmd == 8'h30) st <= e_phase;
            C1: if (is2) cs <= C2;
            C2: if (a555 && cmd == 8'hA0) cs <= C3;
                else if (a555 && cmd == 8'h80 && st == S_IDLE) cs <= C4;
            C3: if (!lck_host && !(st == S_SUSP && sel_host)) begin
                  p_addr <= addr;
                  p_tgt  <= merged;
                  p_d7   <= cmd[7];
                  insusp <= st == S_SUSP;
                  ptmr   <= TW'(PROG_CYC - 1);
                  st     <= S_PW;
                end
            C4: if (is1) cs <= C5;
            C5: if (is2) cs <= C6;
            C6: if (cmd == 8'h10 && chip_mask != '0) begin
                  e_sel  <= chip_mask;
                  e_addr <= '0;
                  st     <= S_EPRE;
                end else if (cmd == 8'h30 && !lck_host) begin
                  e_sel <= host_bit;
                  etmr  <= TW'(WIN_CYC - 1);
                  st    <= S_EWIN;
                end
            default: ;
          endcase
        end
        S_PW: if (ptmr == '0) st <= S_PV;
              else ptmr <= ptmr - TW'(1);
        S_PV: if (arr_rdata == p_tgt) st <= insusp ? S_SUSP : S_IDLE;
              else st <= S_PW;
        S_EWIN: if (wr && cmd == 8'h30) begin
                  if (!lck_host) e_sel <= e_sel | host_bit;
                  etmr <= TW'(WIN_CYC - 1);
                end else if (etmr == '0) begin
                  e_addr <= '0;
                  st     <= S_EPRE;
                end else etmr <= etmr - TW'(1);
        S_EPRE, S_ETIM, S_EWIPE:
          if (wr && cmd == 8'hB0) begin
            e_phase <= st;
            st      <= S_SUSP;
          end else if (st == S_ETIM) begin
            if (etmr == '0) begin e_addr <= '0; st <= S_EWIPE; end
            else etmr <= etmr - TW'(1);
          end else if (!arr_we) begin
            if (!e_last) e_addr <= e_addr + ADDR_W'(1);
            else if (st == S_EPRE) begin
              etmr <= TW'(ERASE_CYC - 1);
              st   <= S_ETIM;
            end else begin
              e_sel <= '0;
              st    <= S_IDLE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always @(posedge clk)
    if (!rst_n) a_r1_ready_in_reset: assert (rdy);

  a_r6_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !rdy);

  a_r11_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !sec_lock[sec_of(arr_addr)]);

  a_r12_vlow_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && vlow) |=> st == S_IDLE);

  a_r5_dq6_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && t6en) |=> tog6 != $past(tog6));

  a_r10_walker_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP) |=> ($stable(e_addr) && $stable(e_sel)));
endmodule

// File: tb/nor_cmd_ctrl_test.sv
module nor_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_n = 1'b1, vlow = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [10:0] sec_lock = '0;
  logic [15:0] dq_out, arr_wdata, arr_rdata;
  logic dq_oe, rdy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [15:0] mem [1 << AW];
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_ctrl #(.ADDR_W(AW), .PROG_CYC(8), .ERASE_CYC(20), .WIN_CYC(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_n(byte_n), .vlow(vlow), .addr(addr), .dq_in(dq_in), .sec_lock(sec_lock),
    .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_rdata(arr_rdata));

  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 16'hFFFF;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; dq_in = d; ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1; ce_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic ln, output logic [15:0] v);
    @(negedge clk); addr = a; dq_in = {ln, 15'h0}; ce_n = 0; oe_n = 0;
    #1 v = dq_out;
    @(negedge clk); oe_n = 1; ce_n = 1;
  endtask

  task automatic unlock();
    wr(AW'(9'h155), 16'h00AA);
    wr(AW'(9'h0AA), 16'h0055);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    unlock(); wr(AW'(9'h155), 16'h00A0); wr(a, d);
  endtask

  task automatic erase_setup();
    unlock(); wr(AW'(9'h155), 16'h0080); unlock();
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 5000 && !rdy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rdy in reset", {15'h0, rdy}, 16'h0001);
    check("R1 no drive in reset", {15'h0, dq_oe}, 16'h0000);
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic t_prog_word();
    logic [15:0] v1, v2;
    prog(9'h070, 16'h1234);
    check("R6 busy after program", {15'h0, rdy}, 16'h0000);
    rd(9'h070, 0, v1); rd(9'h070, 0, v2);
    check("R5 data# bit7", v1 & 16'hFFBB, 16'h0080);
    check("R5/R9 dq6 flips dq2 holds in program", (v1 ^ v2) & 16'h0044, 16'h0040);
    wait_rdy();
    rd(9'h070, 0, v1);
    check("R3 word program", v1, 16'h1234);
    prog(9'h070, 16'hFF0F); wait_rdy();
    rd(9'h070, 0, v1);
    check("R3 AND merge", v1, 16'h1204);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    prog(9'h072, 16'h00F0);
    prog(9'h073, 16'h0000);
    wait_rdy();
    rd(9'h072, 0, v); check("R13 first program done", v, 16'h00F0);
    rd(9'h073, 0, v); check("R13 busy writes ignored", v, 16'hFFFF);
  endtask

  task automatic t_byte();
    logic [15:0] v;
    byte_n = 0;
    prog(9'h0C0, 16'h805A); wait_rdy();
    rd(9'h0C0, 1, v); check("R4 byte lane high", v, 16'h005A);
    rd(9'h0C0, 0, v); check("R4 byte lane low untouched", v, 16'h00FF);
    byte_n = 1;
    rd(9'h0C0, 0, v); check("R4 word view", v, 16'h5AFF);
  endtask

  task automatic t_bad_seq();
    logic [15:0] v;
    wr(9'h155, 16'h00AA); wr(9'h0AA, 16'h0000);
    wr(9'h155, 16'h00A0); wr(9'h074, 16'h0000);
    @(negedge clk);
    check("R2 broken sequence no busy", {15'h0, rdy}, 16'h0001);
    rd(9'h074, 0, v); check("R2 broken sequence no program", v, 16'hFFFF);
  endtask

  task automatic t_vlow();
    logic [15:0] v;
    vlow = 1; prog(9'h075, 16'h0000);
    check("R12 vlow no busy", {15'h0, rdy}, 16'h0001);
    vlow = 0;
    rd(9'h075, 0, v); check("R12 vlow no program", v, 16'hFFFF);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    sec_lock[5] = 1;
    prog(9'h090, 16'h0000);
    check("R11 locked program no busy", {15'h0, rdy}, 16'h0001);
    rd(9'h090, 0, v); check("R11 locked program no effect", v, 16'hFFFF);
  endtask

  task automatic t_sector_erase();
    logic [15:0] v1, v2, v3, v4;
    erase_setup(); wr(9'h070, 16'h0030);
    repeat (WIN + 4) @(negedge clk);
    check("R6 busy in erase", {15'h0, rdy}, 16'h0000);
    rd(9'h070, 0, v1); rd(9'h070, 0, v2);
    check("R5 erase bit7 zero", v1 & 16'h0080, 16'h0000);
    check("R9 dq2 toggles in erasing sector", (v1 ^ v2) & 16'h0044, 16'h0044);
    rd(9'h1A0, 0, v3); rd(9'h1A0, 0, v4);
    check("R9 dq2 holds outside erasing sector", (v3 ^ v4) & 16'h0044, 16'h0040);
    wait_rdy();
    rd(9'h070, 0, v1); check("R7 sector erased", v1, 16'hFFFF);
    rd(9'h07F, 0, v1); check("R7 sector end erased", v1, 16'hFFFF);
    rd(9'h0C0, 0, v1); check("R7 other sector kept", v1, 16'h5AFF);
  endtask

  task automatic t_multi();
    logic [15:0] v;
    prog(9'h100, 16'h00FF); wait_rdy();
    prog(9'h150, 16'h1357); wait_rdy();
    erase_setup(); wr(9'h0C0, 16'h0030); wr(9'h100, 16'h0030);
    wait_rdy();
    rd(9'h0C0, 0, v); check("R7 first added sector", v, 16'hFFFF);
    rd(9'h100, 0, v); check("R7 second added sector", v, 16'hFFFF);
    rd(9'h150, 0, v); check("R7 unselected kept", v, 16'h1357);
  endtask

  task automatic t_suspend();
    logic [15:0] v1, v2;
    prog(9'h1A0, 16'h0F0F); wait_rdy();
    prog(9'h1C8, 16'h1111); wait_rdy();
    erase_setup(); wr(9'h1C8, 16'h0030);
    repeat (WIN + 4) @(negedge clk);
    wr(9'h000, 16'h00B0);
    check("R10 suspended ready", {15'h0, rdy}, 16'h0001);
    rd(9'h1C8, 0, v1); rd(9'h1C8, 0, v2);
    check("R10 selected reads status bit7", v1 & 16'h0080, 16'h0080);
    check("R9/R10 dq2 toggles dq6 held", (v1 ^ v2) & 16'h0044, 16'h0004);
    rd(9'h1A0, 0, v1); check("R10 unselected array read", v1, 16'h0F0F);
    prog(9'h1A1, 16'h2222); wait_rdy();
    rd(9'h1A1, 0, v1); check("R10 program in suspend", v1, 16'h2222);
    prog(9'h1C9, 16'h0000);
    check("R10 program to selected ignored", {15'h0, rdy}, 16'h0001);
    wr(9'h000, 16'h0030);
    check("R10 resume busy", {15'h0, rdy}, 16'h0000);
    wait_rdy();
    rd(9'h1C8, 0, v1); check("R10 erase completed", v1, 16'hFFFF);
    rd(9'h1C9, 0, v1); check("R10 selected unchanged by program", v1, 16'hFFFF);
    rd(9'h1A1, 0, v1); check("R10 suspend program kept", v1, 16'h2222);
  endtask

  task automatic t_chip();
    logic [15:0] v;
    sec_lock[5] = 0; prog(9'h090, 16'h4444); wait_rdy(); sec_lock[5] = 1;
    erase_setup(); wr(9'h155, 16'h0010);
    wait_rdy();
    rd(9'h090, 0, v); check("R11 locked sector survives chip erase", v, 16'h4444);
    rd(9'h1A1, 0, v); check("R8 chip erase", v, 16'hFFFF);
    rd(9'h150, 0, v); check("R8 chip erase other", v, 16'hFFFF);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    erase_setup(); wr(9'h155, 16'h0010);
    repeat (30) @(negedge clk);
    check("R6 chip erase busy", {15'h0, rdy}, 16'h0000);
    rst_n = 0; @(negedge clk);
    check("R1 reset forces ready", {15'h0, rdy}, 16'h0001);
    rst_n = 1; @(negedge clk);
    rd(9'h090, 0, v); check("R1 array read after abort", v, 16'h4444);
    check("R1 idle after abort", {15'h0, rdy}, 16'h0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_prog_word();
    t_busy_ignore();
    t_byte();
    t_bad_seq();
    t_vlow();
    t_lock();
    t_sector_erase();
    t_multi();
    t_suspend();
    t_chip();
    t_abort();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule